// File: doc/BRIEF.md
# Interrupt Event Combiner and Level Selector

This block gathers 128 single-bit event lines and turns them into twelve interrupt requests, one for each maskable core priority level, 4 through 15. A rising or held-high event is caught in a sticky flag. The flags are split into four groups of 32. Each group feeds a combiner that raises its output while any flag in the group is set and not masked.

Each of the twelve outputs has its own selector. A selector either routes a combiner to its level or routes one event flag straight to that level. Event numbers 0 to 3 name the four combiners. Numbers 4 to 127 name individual events, so event flags 0 to 3 can never be set. Software reaches the flags, the masks and the selectors through a plain word-addressed register port. Reads are combinational and writes complete in one cycle. There is no streaming data path, so the port has no valid/ready handshake and never applies back-pressure.

Top module: `irq_event_router`

## Requirements
- R1: After reset every output is low and every flag is clear. Every mask word reads 0xFFFFFFFF. Selectors for levels 12 to 15 (word addresses 40 to 43) read 0x80 to 0x83, which routes combiners 0 to 3 to those levels. All other selectors read 0x00.
- R2: An event input sampled high at a rising clock edge sets flag bit (n mod 32) of flag word n/32, found at word address n/32 (0 to 3). The flag stays set until software clears it. Events 0 to 3 never set a flag, so bits 3:0 of flag word 0 always read 0.
- R3: Writing flag word g clears every flag bit whose data bit is 1. Data bits that are 0 leave their flags unchanged.
- R4: When an event is sampled high in the same cycle that a write clears its flag, the flag ends up set.
- R5: Mask word g sits at word address 16+g and can be written and read back. A mask bit of 1 removes that event from its combiner.
- R6: Combiner g is high while any event in the range 32g to 32g+31 has its flag set and its mask bit clear.
- R7: The selector for level 4+k sits at word address 32+k. Bits 6:0 hold the event number and bit 7 is the enable. While bit 7 is 0, the output for that level is low.
- R8: An enabled selector holding a value from 0 to 3 drives its level from the combiner with that index.
- R9: An enabled selector holding a value from 4 to 127 drives its level from that event's flag. The event's mask bit has no effect on this path.
- R10: Outputs are registered. A change to a flag, mask or selector shows on irq_o one clock edge after the edge that made the change.
- R11: Word addresses outside 0–3, 16–19 and 32–43 read as 0. Writes to them change no flag, mask or selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| evt_i | input | 128 | Event lines, sampled every rising edge |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 10 | Word address (byte address divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_o | output | 12 | Bit k is the request for core level 4+k |

## Verification
An event that sets a flag can arrive in the same cycle that software clears that same flag, and the design must let the set win. The bench provokes this directly: it raises event 40 while clearing bit 8 of flag word 1. Random traffic also mixes events and clear writes on shared words. In both cases the bench judges the result by reading the flag back and by following irq_o against a cycle model. A second overlap is a mask or selector write at the same edge on which the outputs are registered. The bench checks that irq_o still reflects the old setting for that one edge and the new setting on the next.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;

  localparam int unsigned N_EVT     = 128;
  localparam int unsigned GRP_W     = 32;
  localparam int unsigned N_GRP     = N_EVT / GRP_W;
  localparam int unsigned N_LVL     = 12;
  localparam int unsigned EVT_W     = $clog2(N_EVT);
  localparam int unsigned GRP_IDX_W = $clog2(N_GRP);
  localparam int unsigned WADDR_W   = 10;
  localparam int unsigned DATA_W    = GRP_W;

  // word addresses of the three register banks
  localparam int unsigned FLAG_WA = 0;
  localparam int unsigned MASK_WA = 16;
  localparam int unsigned SEL_WA  = 32;

  // event numbers below N_GRP name combiners and never latch
  localparam logic [N_EVT-1:0] LIVE_EVT = ~(N_EVT'((1 << N_GRP) - 1));

  typedef struct packed {
    logic             en;
    logic [EVT_W-1:0] num;
  } sel_t;

  localparam int unsigned SEL_BITS = $bits(sel_t);

  // the top N_GRP levels start out fed by combiners 0..N_GRP-1
  function automatic sel_t sel_reset(input int unsigned k);
    sel_t s;
    s = '0;
    if (k >= N_LVL - N_GRP) begin
      s.en  = 1'b1;
      s.num = EVT_W'(k - (N_LVL - N_GRP));
    end
    return s;
  endfunction

  function automatic logic addr_mapped(input logic [WADDR_W-1:0] a);
    int unsigned w;
    w = 32'(a);
    return (w >= FLAG_WA && w < FLAG_WA + N_GRP) ||
           (w >= MASK_WA && w < MASK_WA + N_GRP) ||
           (w >= SEL_WA  && w < SEL_WA  + N_LVL);
  endfunction

endpackage

// File: rtl/irq_evt_regs.sv
module irq_evt_regs
  import irq_evt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [N_EVT-1:0]    evt_i,
  input  logic                reg_we,
  input  logic [WADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [N_EVT-1:0]    flags_o,
  output logic [N_EVT-1:0]    mask_o,
  output sel_t [N_LVL-1:0]    sel_o
);

  logic [31:0]      waddr;
  logic [N_GRP-1:0] flag_hit;
  logic [N_GRP-1:0] mask_hit;
  logic [N_LVL-1:0] sel_hit;
  logic [N_EVT-1:0] flags_d;

  assign waddr = 32'(reg_addr);

  always_comb begin
    for (int unsigned g = 0; g < N_GRP; g++) begin
      flag_hit[g] = reg_we && (waddr == FLAG_WA + g);
      mask_hit[g] = reg_we && (waddr == MASK_WA + g);
    end
    for (int unsigned k = 0; k < N_LVL; k++) begin
      sel_hit[k] = reg_we && (waddr == SEL_WA + k);
    end
  end

  // clear first, then set: a new event beats a same-cycle clear
  always_comb begin
    flags_d = '0;
    for (int unsigned g = 0; g < N_GRP; g++) begin
      flags_d[g*GRP_W +: GRP_W] =
        (flags_o[g*GRP_W +: GRP_W] & ~({GRP_W{flag_hit[g]}} & reg_wdata))
        | evt_i[g*GRP_W +: GRP_W];
    end
    flags_d = flags_d & LIVE_EVT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_o <= '0;
      mask_o  <= '1;
      for (int unsigned k = 0; k < N_LVL; k++) begin
        sel_o[k] <= sel_reset(k);
      end
    end else begin
      flags_o <= flags_d;
      for (int unsigned g = 0; g < N_GRP; g++) begin
        if (mask_hit[g]) begin
          mask_o[g*GRP_W +: GRP_W] <= reg_wdata;
        end
      end
      for (int unsigned k = 0; k < N_LVL; k++) begin
        if (sel_hit[k]) begin
          sel_o[k] <= sel_t'(reg_wdata[SEL_BITS-1:0]);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int unsigned g = 0; g < N_GRP; g++) begin
      if (waddr == FLAG_WA + g) reg_rdata = flags_o[g*GRP_W +: GRP_W];
      if (waddr == MASK_WA + g) reg_rdata = mask_o[g*GRP_W +: GRP_W];
    end
    for (int unsigned k = 0; k < N_LVL; k++) begin
      if (waddr == SEL_WA + k) reg_rdata = DATA_W'(sel_o[k]);
    end
  end

endmodule

// File: rtl/irq_evt_comb.sv
module irq_evt_comb
  import irq_evt_pkg::*;
(
  input  logic [N_EVT-1:0] flags_i,
  input  logic [N_EVT-1:0] mask_i,
  output logic [N_GRP-1:0] comb_o
);

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign comb_o[g] = |(flags_i[g*GRP_W +: GRP_W] & ~mask_i[g*GRP_W +: GRP_W]);
  end

endmodule

// File: rtl/irq_evt_lvlsel.sv
module irq_evt_lvlsel
  import irq_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  flags_i,
  input  logic [N_GRP-1:0]  comb_i,
  input  sel_t [N_LVL-1:0]  sel_i,
  output logic [N_LVL-1:0]  irq_o
);

  logic [N_LVL-1:0] pick;

  // low event numbers name combiners, the rest name raw flags
  always_comb begin
    pick = '0;
    for (int unsigned k = 0; k < N_LVL; k++) begin
      if (sel_i[k].en) begin
        if (32'(sel_i[k].num) < N_GRP) begin
          pick[k] = comb_i[sel_i[k].num[GRP_IDX_W-1:0]];
        end else begin
          pick[k] = flags_i[sel_i[k].num];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= pick;
  end

endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [N_EVT-1:0]   evt_i,
  input  logic               reg_we,
  input  logic [WADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic [N_LVL-1:0]   irq_o
);

  logic [N_EVT-1:0] flags_q;
  logic [N_EVT-1:0] mask_q;
  sel_t [N_LVL-1:0] sel_q;
  logic [N_GRP-1:0] comb_w;

  irq_evt_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .flags_o   (flags_q),
    .mask_o    (mask_q),
    .sel_o     (sel_q)
  );

  irq_evt_comb u_comb (
    .flags_i (flags_q),
    .mask_i  (mask_q),
    .comb_o  (comb_w)
  );

  irq_evt_lvlsel u_lvl (
    .clk     (clk),
    .rst     (rst),
    .flags_i (flags_q),
    .comb_i  (comb_w),
    .sel_i   (sel_q),
    .irq_o   (irq_o)
  );

endmodule

// File: rtl/irq_event_router_chk.sv
module irq_event_router_chk
  import irq_evt_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [N_EVT-1:0]   evt_i,
  input logic               reg_we,
  input logic [WADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [N_LVL-1:0]   irq_o,
  input logic [N_EVT-1:0]   flags_q,
  input logic [N_EVT-1:0]   mask_q,
  input sel_t [N_LVL-1:0]   sel_q
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == '0))
    else $error("R1 outputs not quiet after reset");

  p_set_beats_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & LIVE_EVT)) |=>
      ((flags_q & $past(evt_i & LIVE_EVT)) == $past(evt_i & LIVE_EVT)))
    else $error("R4 sampled event not latched");

  for (genvar g = 0; g < N_GRP; g++) begin : g_w1c
    p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
      (reg_we && (32'(reg_addr) == FLAG_WA + g)) |=>
        ((flags_q[g*GRP_W +: GRP_W] &
          $past(reg_wdata & ~evt_i[g*GRP_W +: GRP_W])) == '0))
      else $error("R3 written-one flag survived");
  end

  for (genvar k = 0; k < N_LVL; k++) begin : g_lvl
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !sel_q[k].en |=> !irq_o[k])
      else $error("R7 disabled level asserted");

    p_masked_comb_r8: assert property (@(posedge clk) disable iff (rst)
      (sel_q[k].en && (32'(sel_q[k].num) < N_GRP) &&
       (&mask_q[sel_q[k].num[GRP_IDX_W-1:0]*GRP_W +: GRP_W])) |=> !irq_o[k])
      else $error("R8 fully masked combiner asserted a level");
  end

  p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !addr_mapped(reg_addr)) |=> ($stable(mask_q) && $stable(sel_q)))
    else $error("R11 unmapped write changed state");

endmodule

bind irq_event_router irq_event_router_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .evt_i     (evt_i),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .irq_o     (irq_o),
  .flags_q   (flags_q),
  .mask_q    (mask_q),
  .sel_q     (sel_q)
);

// File: tb/test_irq_event_router.sv
`timescale 1ns/100ps
module test_irq_event_router;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] evt = '0;
  logic         we = 1'b0;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [11:0]  irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [127:0] m_flags;
  logic [127:0] m_mask;
  logic [7:0]   m_sel [12];
  logic [31:0]  last_rd;
  logic [11:0]  last_irq;

  always #2.5 clk = ~clk;

  irq_event_router i_irq_event_router (
    .clk (clk), .rst (rst), .evt_i (evt), .reg_we (we), .reg_addr (addr),
    .reg_wdata (wdata), .reg_rdata (rdata), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string rd_tag(input logic [9:0] a);
    int w = int'(a);
    if (w < 4) return "R2 flag read";
    if (w >= 16 && w < 20) return "R5 mask read";
    if (w >= 32 && w < 44) return "R7 selector read";
    return "R11 unmapped read";
  endfunction

  function automatic logic [31:0] model_rd(input logic [9:0] a);
    int w = int'(a);
    if (w < 4) return m_flags[32*w +: 32];
    if (w >= 16 && w < 20) return m_mask[32*(w-16) +: 32];
    if (w >= 32 && w < 44) return {24'h0, m_sel[w-32]};
    return 32'h0;
  endfunction

  function automatic logic [11:0] model_irq();
    logic [11:0] r = '0;
    for (int k = 0; k < 12; k++) begin
      int n = int'(m_sel[k][6:0]);
      if (m_sel[k][7]) begin
        if (n < 4) r[k] = |(m_flags[32*n +: 32] & ~m_mask[32*n +: 32]);
        else       r[k] = m_flags[n];
      end
    end
    return r;
  endfunction

  task automatic model_upd(input logic [127:0] e, input logic w,
                           input logic [9:0] a, input logic [31:0] d);
    logic [127:0] nf = m_flags;
    int ai = int'(a);
    if (w && ai < 4) nf[32*ai +: 32] = nf[32*ai +: 32] & ~d;
    nf = (nf | e) & ~128'hF;
    if (w && ai >= 16 && ai < 20) m_mask[32*(ai-16) +: 32] = d;
    if (w && ai >= 32 && ai < 44) m_sel[ai-32] = d[7:0];
    m_flags = nf;
  endtask

  task automatic model_reset();
    m_flags = '0;
    m_mask  = '1;
    for (int k = 0; k < 12; k++) m_sel[k] = (k >= 8) ? 8'(8'h80 + k - 8) : 8'h00;
  endtask

  // one cycle: read check before the edge, output check after it
  task automatic step(input logic [127:0] e, input logic w,
                      input logic [9:0] a, input logic [31:0] d);
    logic [11:0] exp_irq;
    @(negedge clk);
    evt = e; we = w; addr = a; wdata = d;
    #1;
    last_rd = rdata;
    chk(rd_tag(a), rdata, model_rd(a));
    @(posedge clk);
    exp_irq = model_irq();
    model_upd(e, w, a, d);
    #1;
    last_irq = irq;
    chk("R10 registered output", 32'(irq), 32'(exp_irq));
  endtask

  function automatic logic [127:0] bit128(input int n);
    logic [127:0] v = '0;
    v[n] = 1'b1;
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    step('0, 0, 10'd16, 0); chk("R1 mask word 0", last_rd, 32'hFFFF_FFFF);
    step('0, 0, 10'd19, 0); chk("R1 mask word 3", last_rd, 32'hFFFF_FFFF);
    step('0, 0, 10'd40, 0); chk("R1 selector level 12", last_rd, 32'h80);
    step('0, 0, 10'd43, 0); chk("R1 selector level 15", last_rd, 32'h83);
    step('0, 0, 10'd32, 0); chk("R1 selector level 4", last_rd, 32'h00);

    // R2 latch, sticky, low events ignored
    step(bit128(5) | 128'hF, 0, 10'd0, 0);
    step('0, 0, 10'd0, 0); chk("R2 event 5 latched, 0-3 not", last_rd, 32'h20);
    step('0, 0, 10'd0, 0);
    step('0, 0, 10'd0, 0); chk("R2 flag sticky", last_rd, 32'h20);

    // R3 write-one-to-clear
    step('0, 1, 10'd0, 32'h0);
    step('0, 0, 10'd0, 0); chk("R3 zero write keeps flag", last_rd, 32'h20);
    step('0, 1, 10'd0, 32'h20);
    step('0, 0, 10'd0, 0); chk("R3 one write clears flag", last_rd, 32'h0);

    // R4 set beats clear in the same cycle (event 40 = word 1 bit 8)
    step(bit128(40), 1, 10'd1, 32'h100);
    step('0, 0, 10'd1, 0); chk("R4 set wins over clear", last_rd, 32'h100);
    chk("R6 masked combiner quiet", 32'(last_irq[9]), 32'h0);

    // R5/R6/R8: unmask event 40, combiner 1 feeds level 13 (irq bit 9)
    step('0, 1, 10'd17, ~32'h100);
    chk("R10 mask change not yet visible", 32'(last_irq[9]), 32'h0);
    step('0, 0, 10'd17, 0);
    chk("R5 mask readback", last_rd, 32'hFFFF_FEFF);
    chk("R8 combiner 1 drives level 13", 32'(last_irq[9]), 32'h1);
    step('0, 1, 10'd1, 32'h100);
    step('0, 0, 10'd1, 0);
    chk("R6 combiner drops after clear", 32'(last_irq[9]), 32'h0);

    // R9/R10 direct route of event 70 to level 4, mask ignored
    step('0, 1, 10'd32, 32'hC6);
    step(bit128(70), 0, 10'd2, 0);
    chk("R10 level waits one edge after latch", 32'(last_irq[0]), 32'h0);
    step('0, 0, 10'd2, 0);
    chk("R9 direct route ignores mask", 32'(last_irq[0]), 32'h1);

    // R7 disable bit
    step('0, 1, 10'd32, 32'h46);
    step('0, 0, 10'd32, 0);
    chk("R7 disabled level low", 32'(last_irq[0]), 32'h0);
    chk("R7 selector readback", last_rd, 32'h46);

    // R8 combiner 3 on two levels at once (event 96 = word 3 bit 0)
    step('0, 1, 10'd34, 32'h83);
    step('0, 1, 10'd19, 32'hFFFF_FFFE);
    step(bit128(96), 0, 10'd3, 0);
    step('0, 0, 10'd3, 0);
    chk("R8 combiner 3 on level 6", 32'(last_irq[2]), 32'h1);
    chk("R8 combiner 3 on level 15", 32'(last_irq[11]), 32'h1);

    // R11 unmapped addresses
    step('0, 1, 10'h3FF, 32'hFFFF_FFFF);
    step('0, 1, 10'd20, 32'h0);
    step('0, 1, 10'd44, 32'h0);
    step('0, 0, 10'h3FF, 0); chk("R11 unmapped reads zero", last_rd, 32'h0);
    step('0, 0, 10'd16, 0);  chk("R11 mask untouched", last_rd, 32'hFFFF_FFFF);
    step('0, 0, 10'd40, 0);  chk("R11 selector untouched", last_rd, 32'h80);

    // constrained random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [127:0] e = '0;
      logic         w = 1'b0;
      logic [9:0]   a;
      logic [31:0]  d = $urandom;
      int r = $urandom % 4;
      if (r == 0) e[$urandom % 128] = 1'b1;
      if (r == 1) begin e[$urandom % 128] = 1'b1; e[$urandom % 128] = 1'b1; end
      case ($urandom % 6)
        0: begin w = 1; a = 10'($urandom % 4); end
        1: begin w = 1; a = 10'(16 + $urandom % 4); d = $urandom | $urandom; end
        2: begin
             w = 1; a = 10'(32 + $urandom % 12);
             d = {24'h0, 1'($urandom), ($urandom % 2 == 0) ? 7'($urandom % 4) : 7'($urandom)};
           end
        3: begin w = 1; a = 10'($urandom); end
        default: a = 10'($urandom % 48);
      endcase
      step(e, w, a, d);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule